// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block is the host-facing data window of a network controller's local buffer memory. The host reads or writes one data port repeatedly. Each access reaches the byte at the current remote address, and the address then moves forward by the access width. A remaining-byte count runs down at the same time, and the block raises a one-cycle completion pulse when that count runs out. The address wraps from the receive-ring stop address back to the ring start address. The register bank loads the address and the count and owns the ring bounds and the width-mode bit.

Only two regions can be reached. The first is a 32-byte address image at the bottom of the address space. The image is built from the station MAC address at reset, and again whenever the host does a byte read of the reset port. The second region is the packet memory window. Reads that land anywhere else return all ones. Writes that land anywhere else are dropped. The memory is a synchronous RAM, so read data returns one cycle after the request.

Top module: `rdma_port`

## Requirements
- R1: The access width is set per request. A request with `host_size` of 2 or 3 moves 4 bytes. Otherwise `wide_mode`=1 moves 2 bytes and `wide_mode`=0 moves 1 byte.
- R2: Each counted access adds its width to `cur_addr`. When the sum equals `ring_stop`, `cur_addr` becomes `ring_start` instead.
- R3: When a counted access finds `cur_cnt` at or below the width, `cur_cnt` becomes 0 and `dma_done` is high for one cycle. This happens in the cycle after the request. Otherwise `cur_cnt` drops by the width.
- R4: A data-port write while `cur_cnt` is 0 changes no memory, no address and no count, and raises no `dma_done`. A data-port read while `cur_cnt` is 0 still returns data, advances the address and pulses `dma_done`.
- R5: Byte and 2-byte accesses reach memory only when the effective address is below 32 or inside the window [WIN_BASE, WIN_BASE+WIN_BYTES). A 4-byte access is also reachable when the address is below 32, or when its 4 bytes fit in the window. A read that fails this test returns all ones in its active bytes, and a write that fails it is dropped. In a reachable 4-byte access, a byte whose address falls in neither region reads as 0xFF.
- R6: For 2- and 4-byte accesses, bit 0 of the effective address is forced to 0. The data is little-endian, so the byte at the lowest address is in bits 7:0. Unused upper bytes read as 0.
- R7: After reset, image location j holds image byte j/2. Image bytes 0 to 5 are `mac_addr[8i+7:8i]`, bytes 6 to 13 are 0x00, and bytes 14 and 15 are 0x57.
- R8: A byte read (`host_size`=0) at offset RESET_OFF returns 0 and rebuilds the image. `prom_reload` is high for one cycle after the request. A write to that offset has no effect.
- R9: Every read request gives `host_rvalid` with its `host_rdata` in the next cycle, and only then.
- R10: `ld_addr` and `ld_cnt` load `cur_addr` and `cur_cnt` on the next edge. They take precedence over an advance made in the same cycle.
- R11: A request at any offset other than DATA_OFF, or a reset-port request wider than a byte, moves neither address nor count. As a read, it returns all ones in the bytes its `host_size` names (1, 2 or 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 5 | Port offset within the block |
| host_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| host_wdata | input | 32 | Write data, little-endian |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| wide_mode | input | 1 | 1 = 2-byte transfers for narrow requests |
| ring_start | input | 16 | Receive ring start address |
| ring_stop | input | 16 | Receive ring stop address |
| mac_addr | input | 48 | Station address for the image |
| ld_addr | input | 1 | Load remote address |
| ld_addr_val | input | 16 | Value for ld_addr |
| ld_cnt | input | 1 | Load remaining count |
| ld_cnt_val | input | 16 | Value for ld_cnt |
| cur_addr | output | 16 | Current remote address |
| cur_cnt | output | 16 | Remaining byte count |
| dma_done | output | 1 | Count exhausted pulse |
| prom_reload | output | 1 | Image rebuilt pulse |

## Verification
The hardest cases to reach are the edges of a region. One is an aligned 4-byte access whose last bytes cross the window end, or that starts at 30 and runs past the image. The other is the address landing exactly on the ring stop while the count runs out in the same access. Random addresses rarely hit these, so directed sequences load the address and count right next to each boundary. Seeded random traffic then mixes widths, width modes, offsets and zero counts against a byte-level model of both regions.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W     = 16;
  localparam int LANES      = 4;
  localparam int PROM_BYTES = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } host_size_e;

  typedef enum logic [1:0] {
    LN_PROM = 2'd0,
    LN_WIN  = 2'd1,
    LN_ONES = 2'd2,
    LN_ZERO = 2'd3
  } lane_src_e;

  // bytes moved by one data-port access
  function automatic logic [2:0] step_bytes(logic [1:0] sz, logic wide);
    if (sz[1]) return 3'd4;
    return wide ? 3'd2 : 3'd1;
  endfunction

  // bytes named by host_size alone (for non-data ports)
  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] align_addr(logic [ADDR_W-1:0] a, logic [2:0] nb);
    return (nb > 3'd1) ? {a[ADDR_W-1:1], 1'b0} : a;
  endfunction

  function automatic logic [ADDR_W-1:0] advance_addr(logic [ADDR_W-1:0] a, logic [2:0] nb,
                                                     logic [ADDR_W-1:0] start,
                                                     logic [ADDR_W-1:0] stop);
    logic [ADDR_W-1:0] s;
    s = a + ADDR_W'(nb);
    return (s == stop) ? start : s;
  endfunction

  function automatic logic [ADDR_W-1:0] drain_count(logic [ADDR_W-1:0] c, logic [2:0] nb);
    return (c <= ADDR_W'(nb)) ? '0 : c - ADDR_W'(nb);
  endfunction

  function automatic logic reach_ok(logic [ADDR_W-1:0] ea, logic [2:0] nb, int wb, int we);
    int e;
    e = int'(ea);
    if (e < PROM_BYTES) return 1'b1;
    if (e < wb) return 1'b0;
    return (nb == 3'd4) ? (e + 4 <= we) : (e < we);
  endfunction

  // image location j -> byte
  function automatic logic [7:0] prom_byte(logic [47:0] mac, int j);
    int i;
    i = j / 2;
    if (i < 6) return 8'(mac >> (8 * i));
    if (i >= 14) return 8'h57;
    return 8'h00;
  endfunction
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        nb,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [ADDR_W-1:0] ring_stop,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] ld_addr_val,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] ld_cnt_val,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cnt,
  output logic              done
);
  logic [ADDR_W-1:0] addr_next;
  logic [ADDR_W-1:0] cnt_next;
  logic              runs_out;

  assign addr_next = advance_addr(addr, nb, ring_start, ring_stop);
  assign cnt_next  = drain_count(cnt, nb);
  assign runs_out  = step && !ld_cnt && (cnt <= ADDR_W'(nb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= runs_out;
      if (ld_addr)   addr <= ld_addr_val;
      else if (step) addr <= addr_next;
      if (ld_cnt)    cnt <= ld_cnt_val;
      else if (step) cnt <= cnt_next;
    end
  end

  p_done_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == '0));

  p_cnt_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && (cnt > ADDR_W'(nb))) |=> (cnt == $past(cnt) - ADDR_W'($past(nb))));

  p_addr_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_addr) |=> ((addr == $past(ring_start)) ||
                           (addr == $past(addr) + ADDR_W'($past(nb)))));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt == $past(ld_cnt_val)));
endmodule

// File: rtl/rdma_store.sv
module rdma_store
  import rdma_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [LANES-1:0]  we_lane,
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] lane_a [LANES];
  logic [LANES-1:0]  lane_in;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_a[k]  = base + ADDR_W'(k);
    assign lane_in[k] = (int'(lane_a[k]) < DEPTH);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we_lane[k] && lane_in[k]) mem[lane_a[k][IW-1:0]] <= wdata[8*k +: 8];
      if (rd_en) rdata[8*k +: 8] <= lane_in[k] ? mem[lane_a[k][IW-1:0]] : 8'hFF;
    end
  end
endmodule

// File: rtl/rdma_prom.sv
module rdma_prom
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rebuild,
  input  logic [47:0]       mac,
  input  logic              rd_en,
  input  logic [LANES-1:0]  we_lane,
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  logic [7:0]        img [PROM_BYTES];
  logic [ADDR_W-1:0] lane_a [LANES];
  logic [LANES-1:0]  lane_in;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_a[k]  = base + ADDR_W'(k);
    assign lane_in[k] = (int'(lane_a[k]) < PROM_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < PROM_BYTES; j++) img[j] <= prom_byte(mac, j);
    end else if (rebuild) begin
      for (int j = 0; j < PROM_BYTES; j++) img[j] <= prom_byte(mac, j);
    end else begin
      for (int k = 0; k < LANES; k++)
        if (we_lane[k] && lane_in[k]) img[lane_a[k][4:0]] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (rd_en) rdata[8*k +: 8] <= lane_in[k] ? img[lane_a[k][4:0]] : 8'hFF;
  end

  for (genvar p = 0; p < PROM_BYTES / 2; p++) begin : g_pair
    p_prom_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rebuild) |-> (img[2*p] == img[2*p+1]));
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter logic [4:0]  DATA_OFF  = 5'h10,
  parameter logic [4:0]  RESET_OFF = 5'h1F,
  parameter logic [15:0] WIN_BASE  = 16'h0400,
  parameter int          WIN_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [4:0]  host_off,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        host_rvalid,
  output logic [31:0] host_rdata,
  input  logic        wide_mode,
  input  logic [15:0] ring_start,
  input  logic [15:0] ring_stop,
  input  logic [47:0] mac_addr,
  input  logic        ld_addr,
  input  logic [15:0] ld_addr_val,
  input  logic        ld_cnt,
  input  logic [15:0] ld_cnt_val,
  output logic [15:0] cur_addr,
  output logic [15:0] cur_cnt,
  output logic        dma_done,
  output logic        prom_reload
);
  localparam int WIN_LO = int'(WIN_BASE);
  localparam int WIN_HI = WIN_LO + WIN_BYTES;

  // decoded events
  logic              is_data, is_rst_rd, is_read;
  logic              cnt_empty, wr_go, step;
  logic [2:0]        nb, other_nb;
  logic [ADDR_W-1:0] ea;
  logic              ok;
  logic [LANES-1:0]  lane_prom, lane_win;
  logic [LANES-1:0][1:0] sel_d, sel_q;
  logic [31:0]       prom_rd, win_rd;
  logic              rvalid_q, reload_q;

  assign is_data   = host_req && (host_off == DATA_OFF);
  assign is_read   = host_req && !host_wr;
  assign is_rst_rd = is_read && (host_off == RESET_OFF) && (host_size == SZ_BYTE);
  assign cnt_empty = (cur_cnt == '0);
  assign nb        = step_bytes(host_size, wide_mode);
  assign other_nb  = size_bytes(host_size);
  assign ea        = align_addr(cur_addr, nb);
  assign ok        = reach_ok(ea, nb, WIN_LO, WIN_HI);
  assign wr_go     = is_data && host_wr && !cnt_empty && ok;
  assign step      = is_data && (!host_wr || !cnt_empty);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      int a;
      a = int'(ea) + k;
      lane_prom[k] = ok && (3'(k) < nb) && (a < PROM_BYTES);
      lane_win[k]  = ok && (3'(k) < nb) && (a >= WIN_LO) && (a < WIN_HI);
      if (is_data) begin
        if (3'(k) >= nb)       sel_d[k] = LN_ZERO;
        else if (lane_prom[k]) sel_d[k] = LN_PROM;
        else if (lane_win[k])  sel_d[k] = LN_WIN;
        else                   sel_d[k] = LN_ONES;
      end else if (is_rst_rd) begin
        sel_d[k] = LN_ZERO;
      end else begin
        sel_d[k] = (3'(k) < other_nb) ? LN_ONES : LN_ZERO;
      end
    end
  end

  rdma_ptr u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .nb          (nb),
    .ring_start  (ring_start),
    .ring_stop   (ring_stop),
    .ld_addr     (ld_addr),
    .ld_addr_val (ld_addr_val),
    .ld_cnt      (ld_cnt),
    .ld_cnt_val  (ld_cnt_val),
    .addr        (cur_addr),
    .cnt         (cur_cnt),
    .done        (dma_done)
  );

  rdma_prom u_prom (
    .clk     (clk),
    .rst_n   (rst_n),
    .rebuild (is_rst_rd),
    .mac     (mac_addr),
    .rd_en   (is_read),
    .we_lane (lane_prom & {LANES{wr_go}}),
    .base    (ea),
    .wdata   (host_wdata),
    .rdata   (prom_rd)
  );

  rdma_store #(.DEPTH(WIN_BYTES)) u_win (
    .clk     (clk),
    .rd_en   (is_read),
    .we_lane (lane_win & {LANES{wr_go}}),
    .base    (ea - WIN_BASE),
    .wdata   (host_wdata),
    .rdata   (win_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      reload_q <= 1'b0;
      sel_q    <= '1;
    end else begin
      rvalid_q <= is_read;
      reload_q <= is_rst_rd;
      if (is_read) sel_q <= sel_d;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      case (sel_q[k])
        LN_PROM: host_rdata[8*k +: 8] = prom_rd[8*k +: 8];
        LN_WIN:  host_rdata[8*k +: 8] = win_rd[8*k +: 8];
        LN_ONES: host_rdata[8*k +: 8] = 8'hFF;
        default: host_rdata[8*k +: 8] = 8'h00;
      endcase
    end
  end

  assign host_rvalid = rvalid_q;
  assign prom_reload = reload_q;

  p_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && host_wr && cnt_empty && !ld_addr && !ld_cnt)
      |=> ($stable(cur_addr) && $stable(cur_cnt) && !dma_done));

  p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> host_rvalid);

  p_no_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |=> !host_rvalid);

  p_other_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && (host_off != DATA_OFF) && !ld_addr && !ld_cnt)
      |=> ($stable(cur_addr) && $stable(cur_cnt)));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr) |=> !prom_reload);
endmodule

// File: tb/rdma_port_tb.sv
module rdma_port_tb;
  localparam logic [4:0] DOFF = 5'h10;
  localparam logic [4:0] ROFF = 5'h1F;
  localparam int WB = 16'h0400;
  localparam int WN = 256;
  localparam int WE = WB + WN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [4:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        wide_mode = 1'b0;
  logic [15:0] ring_start = 16'(WB), ring_stop = 16'(WE);
  logic [47:0] mac_addr = 48'h5A_4B_3C_2D_1E_0F;
  logic        ld_addr = 1'b0, ld_cnt = 1'b0;
  logic [15:0] ld_addr_val = '0, ld_cnt_val = '0;
  logic [15:0] cur_addr, cur_cnt;
  logic        dma_done, prom_reload;

  int total = 0;
  int bad = 0;

  logic [7:0]  prom_m [32];
  logic [7:0]  win_m [WN];
  logic [15:0] m_addr = '0, m_cnt = '0;

  always #5 clk = ~clk;

  rdma_port u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(int j);
    int i = j / 2;
    if (i < 6) return mac_addr[8*i +: 8];
    if (i > 13) return 8'h57;
    return 8'h00;
  endfunction

  task automatic rebuild_model();
    for (int j = 0; j < 32; j++) prom_m[j] = img_byte(j);
  endtask

  function automatic logic [7:0] mem_byte(int a);
    if (a < 32) return prom_m[a];
    if (a >= WB && a < WE) return win_m[a - WB];
    return 8'hFF;
  endfunction

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    ld_addr = 1'b1; ld_addr_val = a; ld_cnt = 1'b1; ld_cnt_val = c;
    @(negedge clk);
    ld_addr = 1'b0; ld_cnt = 1'b0;
    m_addr = a; m_cnt = c;
    chk("R10 addr load", 32'(cur_addr), 32'(a));
    chk("R10 cnt load", 32'(cur_cnt), 32'(c));
  endtask

  task automatic access(input bit wr, input logic [4:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    int nb;
    int ea;
    bit ok, step, exp_done, exp_rel;
    logic [31:0] exp_d;
    logic [15:0] na, nc;
    exp_d = '0; exp_done = 0; exp_rel = 0; step = 0;
    na = m_addr; nc = m_cnt;
    if (off == DOFF) begin
      nb = (sz > 1) ? 4 : (wide_mode ? 2 : 1);
      ea = (nb == 1) ? int'(m_addr) : int'(m_addr) - int'(m_addr[0]);
      if (ea < 32) ok = 1;
      else if (nb == 4) ok = (ea >= WB) && (ea + 4 <= WE);
      else ok = (ea >= WB) && (ea < WE);
      for (int k = 0; k < nb; k++) exp_d[8*k +: 8] = ok ? mem_byte(ea + k) : 8'hFF;
      step = !wr || (m_cnt != 0);
      if (step) begin
        na = m_addr + 16'(nb);
        if (na == ring_stop) na = ring_start;
        exp_done = (int'(m_cnt) <= nb);
        nc = exp_done ? 16'd0 : m_cnt - 16'(nb);
      end
      if (wr && m_cnt != 0 && ok)
        for (int k = 0; k < nb; k++) begin
          if (ea + k < 32) prom_m[ea + k] = wd[8*k +: 8];
          else if (ea + k >= WB && ea + k < WE) win_m[ea + k - WB] = wd[8*k +: 8];
        end
    end else if (off == ROFF && sz == 2'd0) begin
      exp_rel = !wr;
    end else begin
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      for (int k = 0; k < nb; k++) exp_d[8*k +: 8] = 8'hFF;
    end
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_off = off; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
    if (exp_rel) rebuild_model();
    if (!wr) chk({tag, " data"}, host_rdata, exp_d);
    chk("R9 rvalid", 32'(host_rvalid), 32'(!wr));
    chk("R1/R2 addr", 32'(cur_addr), 32'(na));
    chk(wr && off == DOFF && m_cnt == 0 ? "R4 cnt" : "R3 cnt", 32'(cur_cnt), 32'(nc));
    chk("R3 done", 32'(dma_done), 32'(exp_done));
    chk("R8 reload", 32'(prom_reload), 32'(exp_rel));
    m_addr = na; m_cnt = nc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rebuild_model();
    for (int i = 0; i < WN; i++) win_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset addr", 32'(cur_addr), 0);
    chk("R3 reset cnt", 32'(cur_cnt), 0);
    chk("R9 reset rvalid", 32'(host_rvalid), 0);

    // R7: image after reset, byte reads
    load(16'd0, 16'd32);
    for (int j = 0; j < 32; j++) access(0, DOFF, 2'd0, 0, "R7 image");

    // fill window with 4-byte writes (R1, R3 completion on last)
    load(16'(WB), 16'(WN));
    for (int i = 0; i < WN / 4; i++) access(1, DOFF, 2'd2, $urandom, "R1 fill");

    // R2: ring wrap at stop with 2-byte reads
    ring_start = 16'(WB + 16); ring_stop = 16'(WB + 48);
    wide_mode = 1'b1;
    load(16'(WB + 44), 16'd6);
    for (int i = 0; i < 4; i++) access(0, DOFF, 2'd0, 0, "R2 wrap");

    // R4: write with zero count is dropped, read still advances
    load(16'(WB + 4), 16'd0);
    access(1, DOFF, 2'd2, 32'hDEADBEEF, "R4 drop");
    access(0, DOFF, 2'd2, 0, "R4 read at zero");
    load(16'(WB + 4), 16'd4);
    access(0, DOFF, 2'd2, 0, "R4 unchanged");

    // R5: unreachable regions
    load(16'h2000, 16'd8);
    access(0, DOFF, 2'd2, 0, "R5 far read");
    load(16'd30, 16'd8);
    access(0, DOFF, 2'd2, 0, "R5 image edge");
    load(16'(WE - 2), 16'd8);
    access(1, DOFF, 2'd2, 32'h11223344, "R5 straddle write");
    load(16'(WE - 2), 16'd8);
    access(0, DOFF, 2'd1, 0, "R5 straddle check");

    // R6: odd address forced even, little-endian
    load(16'(WB + 9), 16'd8);
    access(1, DOFF, 2'd0, 32'h0000A55A, "R6 write");
    load(16'(WB + 9), 16'd8);
    access(0, DOFF, 2'd0, 0, "R6 odd half");
    wide_mode = 1'b0;

    // R8: reset port
    load(16'd0, 16'd1);
    access(1, DOFF, 2'd0, 32'hAA, "R8 patch");
    access(1, ROFF, 2'd0, 0, "R8 write ignored");
    load(16'd0, 16'd4);
    access(0, DOFF, 2'd0, 0, "R8 patched byte");
    access(0, ROFF, 2'd0, 0, "R8 reset read");
    load(16'd0, 16'd4);
    access(0, DOFF, 2'd0, 0, "R8 rebuilt byte");

    // R11: other offsets and wide reset-port reads
    access(0, 5'h05, 2'd1, 0, "R11 other half");
    access(0, 5'h11, 2'd2, 0, "R11 other word");
    access(1, 5'h12, 2'd0, 32'h77, "R11 other write");
    access(0, ROFF, 2'd1, 0, "R11 wide reset port");

    // R10: load wins over same-cycle advance
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_off = DOFF; host_size = 2'd0;
    ld_addr = 1'b1; ld_addr_val = 16'(WB + 100); ld_cnt = 1'b1; ld_cnt_val = 16'd9;
    @(negedge clk);
    host_req = 1'b0; ld_addr = 1'b0; ld_cnt = 1'b0;
    chk("R10 addr precedence", 32'(cur_addr), WB + 100);
    chk("R10 cnt precedence", 32'(cur_cnt), 9);
    chk("R10 no done", 32'(dma_done), 0);
    m_addr = 16'(WB + 100); m_cnt = 16'd9;

    // seeded random traffic
    ring_start = 16'(WB + 32); ring_stop = 16'(WB + 160);
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 100;
      wide_mode = $urandom % 2;
      if (r < 10) begin
        int pick = $urandom % 3;
        logic [15:0] a;
        if (pick == 0) a = 16'($urandom % 34);
        else if (pick == 1) a = 16'(WB - 4 + ($urandom % (WN + 8)));
        else a = 16'($urandom);
        load(a, 16'($urandom % 21));
      end else if (r < 18) begin
        access($urandom % 2, ($urandom % 2) ? ROFF : 5'($urandom % 16),
               2'($urandom), $urandom, "R11 random other");
      end else begin
        access($urandom % 2, DOFF, 2'($urandom), $urandom, "R5 random data");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule